// File: doc/BRIEF.md
# Fixed-Point Rounding Right Shifter

This block divides an N-bit fixed-point operand by a power of two and rounds the quotient. The operand is shifted right by a run-time amount, either logically (unsigned) or arithmetically (signed). A one-bit increment is then added to the kept part. A 2-bit rounding-mode input chooses that increment from the bits that were shifted out.

The four rounding choices are nearest-with-ties-up, nearest-with-ties-to-even, plain truncation and round-to-odd. Round-to-odd folds any lost bits into the result's least significant bit. A shift of zero and a shift of one are fully defined: bit positions below bit 0 read as zero. The block also reports whether any discarded bit was set, so the caller knows the result is inexact.

A parameter selects one registered output stage or a purely combinational path. A datapath places the block after an adder to build averaging or scaling operations.

Top module: `rsh_round_top`

## Requirements
- R1: With the signed select low, the result is the operand shifted right logically by the shift amount, plus the rounding increment r, taken modulo 2^N.
- R2: With the signed select high, the operand is read as two's complement and shifted right arithmetically (sign-filled) before r is added, modulo 2^N.
- R3: Mode code 0 rounds to nearest with ties up: r equals the most significant discarded bit.
- R4: Mode code 1 rounds to nearest with ties to even: r is set when the most significant discarded bit is 1 and either a lower discarded bit is 1 or the kept least significant bit is 1.
- R5: Mode code 2 truncates: r is always 0, so the result equals the floor of the operand divided by 2^d.
- R6: Mode code 3 rounds to odd: r is set when the kept least significant bit is 0 and any discarded bit is 1, so an inexact result is always odd.
- R7: With a shift amount of 0, no rounding takes place in any mode: the result equals the operand and the inexact flag is 0.
- R8: With a shift amount of 1 in mode code 1, r equals operand bit 0 AND operand bit 1.
- R9: The inexact flag is 1 exactly when at least one discarded bit is 1. When it is 0, the result shifted back left by d reproduces the operand.
- R10: The shift amount is $clog2(N) bits wide, so every amount from 0 to N-1 is accepted, N-1 included.
- R11: With REG_OUT=1, result and flag appear one clock after the inputs and are 0 while reset is asserted. With REG_OUT=0, they follow the inputs in the same cycle.
- R12: Adding r never wraps. An unsigned result is never below the truncated value and never above the operand, for example 0xFF shifted by 1 in mode 0 gives 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_i | input | N | Operand to be shifted |
| amt_i | input | $clog2(N) | Right-shift amount, 0 to N-1 |
| sgn_i | input | 1 | 1: arithmetic shift of a signed operand, 0: logical shift |
| mode_i | input | 2 | Rounding mode: 0 nearest-up, 1 nearest-even, 2 truncate, 3 odd |
| res_o | output | N | Rounded, shifted result |
| inexact_o | output | 1 | Any discarded bit was non-zero |

## Verification
The checker assumes that the inputs it samples for one result are those the design consumed for it. With the output register, it holds its own copy of the previous cycle's operand, amount, signedness and mode, and marks the copy valid only after the first edge out of reset. The bench holds every input steady across the capturing edge and across the following sample point. Its stimulus covers every operand, shift amount, signedness and mode of an 8-bit configuration, so every amount stays within 0 to N-1 and no input is left undriven.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
   typedef enum logic [1:0] {
      RM_NEAR_UP   = 2'd0,
      RM_NEAR_EVEN = 2'd1,
      RM_TRUNC     = 2'd2,
      RM_ODD       = 2'd3
   } rmode_e;
endpackage

// File: rtl/rsh_align.sv
// Shifts the operand and extracts the bits the rounding logic needs.
module rsh_align #(
   parameter int N  = 8,
   parameter int DW = $clog2(N)
) (
   input  logic [N-1:0]  v_i,
   input  logic [DW-1:0] d_i,
   input  logic          sgn_i,
   output logic [N-1:0]  shifted_o,
   output logic          guard_o,   // most significant discarded bit
   output logic          sticky_o,  // OR of discarded bits below guard
   output logic          any_o      // OR of all discarded bits
);
   logic signed [N-1:0] v_s;
   logic [N-1:0]        lo_mask;
   logic [N-1:0]        guard_mask;
   logic [N-1:0]        below_mask;

   assign v_s        = v_i;
   // Masks are empty for d = 0, so indices below bit 0 read as zero.
   assign lo_mask    = ~({N{1'b1}} << d_i);
   assign below_mask = lo_mask >> 1;
   assign guard_mask = lo_mask ^ below_mask;

   always_comb begin
      if (sgn_i) shifted_o = N'(v_s >>> d_i);
      else       shifted_o = v_i >> d_i;
   end

   assign guard_o  = |(v_i & guard_mask);
   assign sticky_o = |(v_i & below_mask);
   assign any_o    = |(v_i & lo_mask);
endmodule

// File: rtl/rsh_incr.sv
// Chooses the rounding increment for the selected mode.
module rsh_incr
   import rsh_pkg::*;
(
   input  rmode_e mode_i,
   input  logic   guard_i,
   input  logic   sticky_i,
   input  logic   any_i,
   input  logic   lsb_i,
   output logic   inc_o
);
   always_comb begin
      unique case (mode_i)
         RM_NEAR_UP:   inc_o = guard_i;
         RM_NEAR_EVEN: inc_o = guard_i & (sticky_i | lsb_i);
         RM_TRUNC:     inc_o = 1'b0;
         RM_ODD:       inc_o = ~lsb_i & any_i;
         default:      inc_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/rsh_round_top.sv
module rsh_round_top
   import rsh_pkg::*;
#(
   parameter int N       = 8,
   parameter int REG_OUT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         opnd_i,
   input  logic [$clog2(N)-1:0] amt_i,
   input  logic                 sgn_i,
   input  logic [1:0]           mode_i,
   output logic [N-1:0]         res_o,
   output logic                 inexact_o
);
   localparam int DW = $clog2(N);

   if (N < 2) begin : g_bad_width
      $error("rsh_round_top: N must be at least 2");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("rsh_round_top: REG_OUT must be 0 or 1");
   end

   logic [N-1:0] shifted;
   logic         guard, sticky, any_disc, inc;
   logic [N-1:0] sum;

   rsh_align #(.N(N), .DW(DW)) u_align (
      .v_i       (opnd_i),
      .d_i       (amt_i),
      .sgn_i     (sgn_i),
      .shifted_o (shifted),
      .guard_o   (guard),
      .sticky_o  (sticky),
      .any_o     (any_disc)
   );

   rsh_incr u_incr (
      .mode_i   (rmode_e'(mode_i)),
      .guard_i  (guard),
      .sticky_i (sticky),
      .any_i    (any_disc),
      .lsb_i    (shifted[0]),
      .inc_o    (inc)
   );

   // Cannot wrap: for d >= 1 the shifted value leaves headroom for +1.
   assign sum = shifted + N'(inc);

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o     <= '0;
            inexact_o <= 1'b0;
         end else begin
            res_o     <= sum;
            inexact_o <= any_disc;
         end
      end
   end else begin : g_comb
      assign res_o     = sum;
      assign inexact_o = any_disc;
   end
endmodule

// File: rtl/rsh_round_chk.sv
module rsh_round_chk
   import rsh_pkg::*;
#(
   parameter int N       = 8,
   parameter int REG_OUT = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N-1:0]         opnd_i,
   input logic [$clog2(N)-1:0] amt_i,
   input logic                 sgn_i,
   input logic [1:0]           mode_i,
   input logic [N-1:0]         res_o,
   input logic                 inexact_o
);
   localparam int DW = $clog2(N);

   logic [N-1:0]  s_v;
   logic [DW-1:0] s_d;
   logic          s_s;
   logic [1:0]    s_m;
   logic          s_vld;

   if (REG_OUT == 1) begin : g_lat1
      logic [N-1:0]  c_v;
      logic [DW-1:0] c_d;
      logic          c_s;
      logic [1:0]    c_m;
      logic          c_vld;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_v <= '0; c_d <= '0; c_s <= 1'b0; c_m <= '0; c_vld <= 1'b0;
         end else begin
            c_v <= opnd_i; c_d <= amt_i; c_s <= sgn_i; c_m <= mode_i; c_vld <= 1'b1;
         end
      end
      assign s_v = c_v; assign s_d = c_d; assign s_s = c_s;
      assign s_m = c_m; assign s_vld = c_vld;
   end else begin : g_lat0
      assign s_v = opnd_i; assign s_d = amt_i; assign s_s = sgn_i;
      assign s_m = mode_i; assign s_vld = 1'b1;
   end

   p_zero_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && s_d == '0 |-> res_o == s_v && !inexact_o);

   p_unsigned_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && !s_s |-> res_o <= s_v);

   p_odd_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && s_m == RM_ODD && inexact_o |-> res_o[0]);

   p_exact_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && !inexact_o |-> N'(res_o << s_d) == s_v);

   p_trunc_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && s_m == RM_TRUNC && !s_s |-> N'(res_o << s_d) <= s_v);
endmodule

bind rsh_round_top rsh_round_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_rsh_round_top.sv
module tb_rsh_round_top;
   localparam int N  = 8;
   localparam int DW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  opnd = '0;
   logic [DW-1:0] amt = '0;
   logic          sgn = 1'b0;
   logic [1:0]    mode = '0;
   logic [N-1:0]  res;
   logic          inexact;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rsh_round_top #(.N(N), .REG_OUT(1)) dut (
      .clk(clk), .rst_n(rst_n), .opnd_i(opnd), .amt_i(amt), .sgn_i(sgn),
      .mode_i(mode), .res_o(res), .inexact_o(inexact)
   );

   // Arithmetic reference: floor quotient, positive remainder, mode rule.
   function automatic void ref_model(input int v, input int d, input int s, input int m,
                                     output int r_out, output bit ix_out);
      int val, p, rem, q, half;
      bit inc;
      val = v;
      if (s != 0 && v >= (1 << (N-1))) val = v - (1 << N);
      p    = 1 << d;
      rem  = ((val % p) + p) % p;
      q    = (val - rem) / p;
      half = p / 2;
      inc  = 1'b0;
      case (m)
         0: inc = (d > 0) && (rem >= half);
         1: inc = (d > 0) && ((rem > half) || (rem == half && (q & 1) != 0));
         2: inc = 1'b0;
         3: inc = (rem != 0) && ((q & 1) == 0);
         default: inc = 1'b0;
      endcase
      r_out  = (q + int'(inc)) & ((1 << N) - 1);
      ix_out = (rem != 0);
   endfunction

   function automatic string tag_of(input int d, input int s, input int m);
      if (d == 0) return "R7";
      if (d == 1 && m == 1) return "R8";
      if (d == N-1) return "R10";
      case (m)
         0: return s ? "R2/R3" : "R1/R3";
         1: return s ? "R2/R4" : "R1/R4";
         2: return s ? "R2/R5" : "R1/R5";
         default: return s ? "R2/R6" : "R1/R6";
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input int v, input int d, input int s, input int m,
                          input string req);
      int er;
      bit ex;
      @(negedge clk);
      opnd = N'(v); amt = DW'(d); sgn = s[0]; mode = m[1:0];
      @(negedge clk);   // captured at the posedge in between (R11 latency)
      ref_model(v, d, s, m, er, ex);
      check(req, int'(res), er);
      check("R9", int'(inexact), int'(ex));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      opnd = 8'hA5; amt = 3'd3; mode = 2'd0;
      repeat (3) @(negedge clk);
      // R11: outputs held at zero during reset
      check("R11", int'(res), 0);
      check("R11", int'(inexact), 0);
      rst_n = 1'b1;

      // Directed corners
      run_vec(8'hFF, 1, 0, 0, "R12");   // 0x7F + 1 = 0x80, no wrap
      run_vec(8'h80, N-1, 1, 0, "R10"); // -128 >> 7 = -1 exactly -> 0xFF
      run_vec(8'h03, 1, 0, 1, "R8");    // tie, odd kept bit -> 2
      run_vec(8'h01, 1, 0, 1, "R8");    // tie, even kept bit -> 0
      run_vec(8'h5A, 0, 1, 3, "R7");    // no rounding at d=0

      // Exhaustive sweep over the 8-bit configuration
      for (int v = 0; v < (1 << N); v++)
         for (int d = 0; d < N; d++)
            for (int s = 0; s < 2; s++)
               for (int m = 0; m < 4; m++)
                  run_vec(v, d, s, m, tag_of(d, s, m));

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule